// File: doc/BRIEF.md
# Windowed Watchdog Timer with Write Lock

This block supervises software by counting a 12-bit value down from a reload value at a rate set by a power-of-two prescaler. Software must service it inside a window. If the count runs out, the block raises a one-cycle reset request. If software services it too early, while the count is still above a programmable threshold, that also raises the request. After either event the count restarts from the reload value.

Software talks to the block through a single-cycle write port. The port has four targets: a service (kick) register, a lock register, a configuration register holding the reload value and the prescaler exponent, and a window register holding the threshold. The port has no back-pressure. A write is taken in the cycle `wr_en` is high and never stalls. Configuration and window writes are dropped while the lock is closed. The lock is closed after reset. A debug-halt input freezes the prescaler and the counter, so a halted processor does not trip the watchdog.

Top module: `wdw_top`

## Requirements
- R1: After reset, `wd_count` is 0xFFF, `wd_rst_req` is 0 and `wd_locked` is 1. The reload value and the window threshold are both 0xFFF, and the prescaler exponent is 0.
- R2: With prescaler exponent N (configuration bits [14:12], wr_sel 2), the count drops by one once every 2^N clock cycles while not halted. The reload value is configuration bits [11:0].
- R3: A prescaler tick that finds the count at 0 is an underflow. It raises `wd_rst_req` on the next cycle and loads the reload value into the count.
- R4: Writing 0x5FA0 to wr_sel 0 while the count is at or below the threshold (window bits [11:0], wr_sel 3) reloads the count and restarts the prescaler. It raises no reset request.
- R5: Writing 0x5FA0 to wr_sel 0 while the count is above the threshold raises `wd_rst_req` on the next cycle. It also reloads the count.
- R6: A write to wr_sel 0 with any value other than 0x5FA0 leaves the count and `wd_rst_req` unaffected.
- R7: Writing 0xA55A to wr_sel 1 opens the lock (`wd_locked` = 0). Writing any other value to wr_sel 1 closes it.
- R8: While the lock is closed, writes to wr_sel 2 and wr_sel 3 are ignored.
- R9: While `dbg_halt` is high, the prescaler and the count hold their values.
- R10: `wd_rst_req` is high for exactly one cycle per fault event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt | input | 1 | Freezes counting while high |
| wr_en | input | 1 | Write strobe, accepted the same cycle |
| wr_sel | input | 2 | Target: 0 kick, 1 lock, 2 config, 3 window |
| wr_data | input | 16 | Write value |
| wd_count | output | 12 | Current count |
| wd_locked | output | 1 | 1 while configuration writes are blocked |
| wd_rst_req | output | 1 | One-cycle reset request |

## Verification
Every result of a write or a tick is due one clock edge later. The count, the lock state and the reset request all change on the edge that samples the write. A reset request therefore appears in the cycle after the faulting kick or the underflowing tick. The bench drives inputs at the falling edge and lets one rising edge pass. It then compares all outputs at the next falling edge against a cycle model that advances on the same edge. The directed prescaler and underflow checks count elapsed cycles. They expect the first decrement after exactly 2^N cycles and the underflow after (reload+1)·2^N cycles.

// File: rtl/wdw_pkg.sv
package wdw_pkg;
  typedef enum logic [1:0] {
    SEL_KICK = 2'd0,
    SEL_LOCK = 2'd1,
    SEL_CFG  = 2'd2,
    SEL_WIN  = 2'd3
  } wdw_sel_e;

  localparam logic [15:0] KICK_KEY_DEF   = 16'h5FA0;
  localparam logic [15:0] UNLOCK_KEY_DEF = 16'hA55A;
endpackage

// File: rtl/wdw_regs.sv
module wdw_regs
  import wdw_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned PSC_W      = 3,
  parameter int unsigned DATA_W     = 16,
  parameter logic [15:0] KICK_KEY   = KICK_KEY_DEF,
  parameter logic [15:0] UNLOCK_KEY = UNLOCK_KEY_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              locked_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [CNT_W-1:0]  delta_o,
  output logic [PSC_W-1:0]  psc_o,
  output logic              kick_o
);
  localparam int unsigned PSC_LO = CNT_W;
  localparam int unsigned PSC_HI = CNT_W + PSC_W - 1;

  wdw_sel_e sel;
  logic     cfg_open;

  assign sel      = wdw_sel_e'(wr_sel);
  assign cfg_open = wr_en && !locked_o;
  assign kick_o   = wr_en && (sel == SEL_KICK) && (wr_data == DATA_W'(KICK_KEY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_o <= 1'b1;
    end else if (wr_en && sel == SEL_LOCK) begin
      locked_o <= (wr_data != DATA_W'(UNLOCK_KEY));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_o <= '1;
      psc_o    <= '0;
    end else if (cfg_open && sel == SEL_CFG) begin
      reload_o <= wr_data[CNT_W-1:0];
      psc_o    <= wr_data[PSC_HI:PSC_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      delta_o <= '1;
    end else if (cfg_open && sel == SEL_WIN) begin
      delta_o <= wr_data[CNT_W-1:0];
    end
  end

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_o && wr_en && (sel == SEL_CFG || sel == SEL_WIN))
      |=> ($stable(reload_o) && $stable(delta_o) && $stable(psc_o))); // R8

  AST_LOCK_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_LOCK) |=> (locked_o == ($past(wr_data) != DATA_W'(UNLOCK_KEY)))); // R7
endmodule

// File: rtl/wdw_prescaler.sv
module wdw_prescaler #(
  parameter int unsigned PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_i,
  input  logic             clear_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (1 << PSC_W) - 1;

  logic [DIV_W-1:0] limit;
  logic [DIV_W-1:0] cnt_q;

  // limit = 2^N - 1 as a thermometer code
  for (genvar g = 0; g < DIV_W; g++) begin : g_limit
    assign limit[g] = (psc_i > PSC_W'(g));
  end

  assign tick_o = !halt_i && (cnt_q >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (!halt_i) begin
      if (tick_o) cnt_q <= '0;
      else        cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  AST_PSC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0)); // R4

  AST_PSC_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i && !clear_i) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/wdw_counter.sv
module wdw_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [CNT_W-1:0] delta_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rst_req_o
);
  logic early;
  logic under;

  assign early = kick_i && (cnt_o > delta_i);
  assign under = !kick_i && tick_i && (cnt_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '1;
    end else if (kick_i || under) begin
      cnt_o <= reload_i;
    end else if (tick_i) begin
      cnt_o <= cnt_o - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_o <= 1'b0;
    else        rst_req_o <= early || under;
  end

  AST_UNDERFLOW_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !kick_i && cnt_o == '0) |=> (rst_req_o && cnt_o == $past(reload_i))); // R3

  AST_EARLY_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && cnt_o > delta_i) |=> rst_req_o); // R5

  AST_WINDOW_KICK: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_i && cnt_o <= delta_i) |=> (!rst_req_o && cnt_o == $past(reload_i))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick_i && !tick_i) |=> ($stable(cnt_o) && !rst_req_o)); // R2
endmodule

// File: rtl/wdw_top.sv
module wdw_top
  import wdw_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned PSC_W      = 3,
  parameter int unsigned DATA_W     = 16,
  parameter logic [15:0] KICK_KEY   = KICK_KEY_DEF,
  parameter logic [15:0] UNLOCK_KEY = UNLOCK_KEY_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_halt,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  wd_count,
  output logic              wd_locked,
  output logic              wd_rst_req
);
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] delta;
  logic [PSC_W-1:0] psc;
  logic             kick;
  logic             tick;

  wdw_regs #(
    .CNT_W(CNT_W), .PSC_W(PSC_W), .DATA_W(DATA_W),
    .KICK_KEY(KICK_KEY), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .locked_o(wd_locked), .reload_o(reload), .delta_o(delta), .psc_o(psc), .kick_o(kick)
  );

  wdw_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .halt_i(dbg_halt), .clear_i(kick),
    .psc_i(psc), .tick_o(tick)
  );

  wdw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .kick_i(kick),
    .reload_i(reload), .delta_i(delta), .cnt_o(wd_count), .rst_req_o(wd_rst_req)
  );

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !kick) |=> ($stable(wd_count) && !wd_rst_req)); // R9

  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0 && wr_data != DATA_W'(KICK_KEY) && dbg_halt) |=> $stable(wd_count)); // R6
endmodule

// File: tb/wdw_top_tb.sv
module wdw_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'h0;
  logic [11:0] wd_count;
  logic        wd_locked;
  logic        wd_rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [11:0] m_cnt, m_rel, m_dlt;
  logic [2:0]  m_psc;
  logic [6:0]  m_p;
  logic        m_lock, m_rst;

  always #2 clk = ~clk;

  wdw_top u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wd_count(wd_count), .wd_locked(wd_locked), .wd_rst_req(wd_rst_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] lim_of(input logic [2:0] n);
    return 7'((8'd1 << n) - 8'd1);
  endfunction

  task automatic model_step(input bit we, input logic [1:0] sel, input logic [15:0] d, input bit h);
    bit kick;
    kick = we && sel == 2'd0 && d == 16'h5FA0;
    m_rst = 1'b0;
    if (kick) begin
      m_rst = (m_cnt > m_dlt);
      m_cnt = m_rel;
      m_p   = '0;
    end else if (!h) begin
      if (m_p >= lim_of(m_psc)) begin
        m_p = '0;
        if (m_cnt == 12'd0) begin m_cnt = m_rel; m_rst = 1'b1; end
        else m_cnt = m_cnt - 12'd1;
      end else m_p = m_p + 7'd1;
    end
    if (we && sel == 2'd1) m_lock = (d != 16'hA55A);
    else if (we && !m_lock && sel == 2'd2) begin m_rel = d[11:0]; m_psc = d[14:12]; end
    else if (we && !m_lock && sel == 2'd3) m_dlt = d[11:0];
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit we, input logic [1:0] sel, input logic [15:0] d, input bit h);
    wr_en = we; wr_sel = sel; wr_data = d; dbg_halt = h;
    @(posedge clk);
    model_step(we, sel, d, h);
    @(negedge clk);
    chk(wd_count == m_cnt, "R3 count", int'(wd_count), int'(m_cnt));
    chk(wd_rst_req == m_rst, "R10 rst_req", int'(wd_rst_req), int'(m_rst));
    chk(wd_locked == m_lock, "R7 locked", int'(wd_locked), int'(m_lock));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 16'h0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'd4711));
    m_cnt = 12'hFFF; m_rel = 12'hFFF; m_dlt = 12'hFFF; m_psc = 3'd0;
    m_p = '0; m_lock = 1'b1; m_rst = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(wd_count == 12'hFFF, "R1 count", int'(wd_count), 12'hFFF);
    chk(wd_locked == 1'b1, "R1 locked", int'(wd_locked), 1);
    chk(wd_rst_req == 1'b0, "R1 rst_req", int'(wd_rst_req), 0);

    cyc(1'b1, 2'd1, 16'hA55A, 1'b0);
    chk(wd_locked == 1'b0, "R7 unlock", int'(wd_locked), 0);
    cyc(1'b1, 2'd2, {1'b0, 3'd2, 12'd20}, 1'b0);
    cyc(1'b1, 2'd3, 16'd8, 1'b0);
    cyc(1'b1, 2'd1, 16'h0000, 1'b0);
    chk(wd_locked == 1'b1, "R7 relock", int'(wd_locked), 1);
    cyc(1'b1, 2'd2, {1'b0, 3'd0, 12'd50}, 1'b0);
    cyc(1'b1, 2'd0, 16'h5FA0, 1'b0);
    chk(wd_rst_req == 1'b1, "R5 early kick", int'(wd_rst_req), 1);
    chk(wd_count == 12'd20, "R8 reload kept", int'(wd_count), 20);
    idle(1);
    chk(wd_rst_req == 1'b0, "R10 one cycle", int'(wd_rst_req), 0);
    idle(2);
    chk(wd_count == 12'd20, "R2 before tick", int'(wd_count), 20);
    idle(1);
    chk(wd_count == 12'd19, "R2 after 4", int'(wd_count), 19);
    cyc(1'b1, 2'd0, 16'h1234, 1'b1);
    chk(wd_count == 12'd19 && !wd_rst_req, "R6 bad key", int'(wd_count), 19);
    for (int i = 0; i < 10; i++) cyc(1'b0, 2'd0, 16'h0, 1'b1);
    chk(wd_count == 12'd19, "R9 halt", int'(wd_count), 19);
    idle(44);
    chk(wd_count == 12'd8, "R4 at window", int'(wd_count), 8);
    cyc(1'b1, 2'd0, 16'h5FA0, 1'b0);
    chk(wd_rst_req == 1'b0 && wd_count == 12'd20, "R4 window kick", int'(wd_rst_req), 0);
    n = 0;
    for (int i = 0; i < 200; i++) begin
      idle(1); n++;
      if (wd_rst_req) break;
    end
    chk(n == 84, "R3 underflow cycles", n, 84);
    chk(wd_count == 12'd20, "R3 underflow reload", int'(wd_count), 20);

    // constrained random phase
    cyc(1'b1, 2'd1, 16'hA55A, 1'b0);
    for (int i = 0; i < 6000; i++) begin
      int r;
      bit h;
      r = int'($urandom % 100);
      h = ($urandom % 10) == 0;
      if (r < 4)       cyc(1'b1, 2'd2, {1'b0, 3'($urandom % 3), 12'($urandom % 48)}, h);
      else if (r < 7)  cyc(1'b1, 2'd3, 16'($urandom % 48), h);
      else if (r < 9)  cyc(1'b1, 2'd1, ($urandom % 2) ? 16'hA55A : 16'($urandom), h);
      else if (r < 16) cyc(1'b1, 2'd0, ($urandom % 5) ? 16'h5FA0 : 16'($urandom), h);
      else             cyc(1'b0, 2'd0, 16'h0, h);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule